// File: doc/BRIEF.md
# Latched Alarm and Event Status Register with Interrupt

This block holds the sticky status flags of a line framer. Each of its `W` inputs carries one condition. Some inputs are level-type alarms and the rest are pulse-type events. A condition sets its own latched status bit. That bit stays set until the host explicitly clears it, so a short event is never lost between two host visits.

The host works through a single write port with a two-bit operation code and does three things:
- **Refresh:** copies chosen latched bits into a read image, which it then reads.
- **Clear:** clears chosen latched bits. The normal value to write is the one just read, masked by the refresh selection.
- **Load mask:** loads an interrupt mask.

A refresh also acknowledges the pending interrupts of the bits it selects. The active-low interrupt line is low while any unmasked bit still has an unacknowledged interrupt.

Alarm bits raise an interrupt both when their alarm appears and when it goes away. Event bits raise one only on occurrence. Per bit, an event is set up either to raise the interrupt in every cycle the event is present, or to raise it once per appearance.

Top module: `status_latch_irq`

## Requirements
- R1: After reset, all latched bits, the read image and the interrupt mask are zero, and `irq_n` is high.
- R2: A condition input at 1 on a clock edge sets its latched bit. The bit stays 1 after the condition returns to 0, until it is cleared.
- R3: A write with `host_op` = 2'b00 (refresh) loads each image position whose data bit is 1 from the latched bit. Positions whose data bit is 0 keep their previous image value.
- R4: A write with `host_op` = 2'b01 (clear) zeroes the latched bits whose data bit is 1. An alarm bit whose input is still 1 stays set, and bits whose data bit is 0 are untouched.
- R5: If a condition is 1 in the same cycle as a clear of its bit, the bit stays set.
- R6: An alarm bit (default bits 0 to 3, parameter `ALARM_BITS`) becomes interrupt-pending on every change of its input, both 0 to 1 and 1 to 0.
- R7: A repeating event bit (default bits 6 and 7, the bits in neither `ALARM_BITS` nor `ONCE_BITS`) becomes pending in every cycle its input is 1. An acknowledge is therefore overridden while the event persists.
- R8: A single-shot event bit (default bits 4 and 5, parameter `ONCE_BITS`) becomes pending only when its input goes from 0 to 1. It does not become pending while the input stays high, nor when the input falls.
- R9: A refresh with data bit 1 acknowledges that bit's pending interrupt, even if its alarm is still present.
- R10: A write with `host_op` = 2'b10 loads the interrupt mask. `irq_n` is low exactly when some bit is both pending and has its mask bit set at 1.
- R11: A write with `host_op` = 2'b11 changes neither the image, the mask, the latched bits nor the pending interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cond_in | input | W | Alarm levels and event pulses, one per status bit |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_op | input | 2 | 00 refresh, 01 clear, 10 load interrupt mask, 11 no operation |
| host_data | input | W | Selection or mask value of the write |
| image_out | output | W | Read image seen by the host |
| irq_n | output | 1 | Interrupt, active low |

## Verification
Two pairs of functions can collide in one cycle.

The first pair is a condition setting a bit and the host clearing that same bit. The bench raises an event on the very clock edge that carries a clear of its bit. It then refreshes, and expects the bit still set in the image.

The second pair is a new interrupt cause and the host acknowledge. The bench holds a repeating event high across the refresh that acknowledges it, and expects `irq_n` to stay low. With a single-shot event in the same position it expects `irq_n` to return high.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    localparam int MAX_W = 32;

    typedef enum logic [1:0] {
        OP_REFRESH = 2'b00,
        OP_CLEAR   = 2'b01,
        OP_IMASK   = 2'b10,
        OP_NONE    = 2'b11
    } host_op_e;

    typedef enum logic [1:0] {
        KIND_ALARM    = 2'd0,
        KIND_EVT_EACH = 2'd1,
        KIND_EVT_ONCE = 2'd2
    } bit_kind_e;

    typedef struct packed {
        logic refresh;
        logic clear;
        logic load_mask;
    } host_strobe_t;

    function automatic host_strobe_t decode_op(input logic wr, input logic [1:0] op);
        host_strobe_t s;
        s.refresh   = wr && (host_op_e'(op) == OP_REFRESH);
        s.clear     = wr && (host_op_e'(op) == OP_CLEAR);
        s.load_mask = wr && (host_op_e'(op) == OP_IMASK);
        return s;
    endfunction

    function automatic bit_kind_e kind_of(input int idx,
                                          input logic [MAX_W-1:0] alarm_sel,
                                          input logic [MAX_W-1:0] once_sel);
        if (alarm_sel[idx])
            return KIND_ALARM;
        else if (once_sel[idx])
            return KIND_EVT_ONCE;
        else
            return KIND_EVT_EACH;
    endfunction

endpackage

// File: rtl/ssr_bit_cell.sv
module ssr_bit_cell
    import ssr_pkg::*;
#(
    parameter bit_kind_e KIND = KIND_ALARM
) (
    input  logic clk,
    input  logic rst,
    input  logic cond,
    input  logic clr,
    input  logic ack,
    output logic latched,
    output logic pending
);

    logic pend_set;

    generate
        if (KIND == KIND_EVT_EACH) begin : g_each
            assign pend_set = cond;
        end else begin : g_edge
            logic cond_q;
            always_ff @(posedge clk) begin
                if (rst) cond_q <= 1'b0;
                else     cond_q <= cond;
            end
            if (KIND == KIND_ALARM) begin : g_alarm
                assign pend_set = cond ^ cond_q;
            end else begin : g_once
                assign pend_set = cond & ~cond_q;
            end
        end
    endgenerate

    // a new cause always wins over a clear or an acknowledge in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            latched <= 1'b0;
            pending <= 1'b0;
        end else begin
            latched <= cond | (latched & ~clr);
            pending <= pend_set | (pending & ~ack);
        end
    end

endmodule

// File: rtl/ssr_host_regs.sv
module ssr_host_regs
    import ssr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  host_strobe_t stb,
    input  logic [W-1:0] data,
    input  logic [W-1:0] status,
    output logic [W-1:0] clr_vec,
    output logic [W-1:0] ack_vec,
    output logic [W-1:0] image_q,
    output logic [W-1:0] imask_q
);

    always_comb begin
        clr_vec = stb.clear   ? data : '0;
        ack_vec = stb.refresh ? data : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            image_q <= '0;
            imask_q <= '0;
        end else begin
            if (stb.refresh)
                image_q <= (data & status) | (~data & image_q);
            if (stb.load_mask)
                imask_q <= data;
        end
    end

endmodule

// File: rtl/status_latch_irq.sv
module status_latch_irq
    import ssr_pkg::*;
#(
    parameter int         W          = 8,
    parameter logic [W-1:0] ALARM_BITS = 8'h0F,
    parameter logic [W-1:0] ONCE_BITS  = 8'h30
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cond_in,
    input  logic         host_wr,
    input  logic [1:0]   host_op,
    input  logic [W-1:0] host_data,
    output logic [W-1:0] image_out,
    output logic         irq_n
);

    localparam logic [MAX_W-1:0] ALARM_X = MAX_W'(ALARM_BITS);
    localparam logic [MAX_W-1:0] ONCE_X  = MAX_W'(ONCE_BITS);

    host_strobe_t   stb;
    logic [W-1:0]   status_vec;
    logic [W-1:0]   pend_vec;
    logic [W-1:0]   clr_vec;
    logic [W-1:0]   ack_vec;
    logic [W-1:0]   imask_vec;

    assign stb = decode_op(host_wr, host_op);

    ssr_host_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .stb     (stb),
        .data    (host_data),
        .status  (status_vec),
        .clr_vec (clr_vec),
        .ack_vec (ack_vec),
        .image_q (image_out),
        .imask_q (imask_vec)
    );

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            localparam bit_kind_e K = kind_of(i, ALARM_X, ONCE_X);
            ssr_bit_cell #(.KIND(K)) u_cell (
                .clk     (clk),
                .rst     (rst),
                .cond    (cond_in[i]),
                .clr     (clr_vec[i]),
                .ack     (ack_vec[i]),
                .latched (status_vec[i]),
                .pending (pend_vec[i])
            );
        end
    endgenerate

    assign irq_n = ~|(pend_vec & imask_vec);

endmodule

// File: rtl/status_latch_irq_chk.sv
module status_latch_irq_chk #(
    parameter int         W          = 8,
    parameter logic [W-1:0] ALARM_BITS = 8'h0F,
    parameter logic [W-1:0] ONCE_BITS  = 8'h30
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] cond_in,
    input logic         host_wr,
    input logic [1:0]   host_op,
    input logic [W-1:0] host_data,
    input logic [W-1:0] image_q,
    input logic         irq_n,
    input logic [W-1:0] status_q,
    input logic [W-1:0] pend_q,
    input logic [W-1:0] imask_q
);

    localparam logic [W-1:0] EACH_BITS = ~(ALARM_BITS | ONCE_BITS);

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    always @(posedge clk) begin
        if (rst_d === 1'b1) begin
            assert_reset_state_R1: assert (image_q == '0 && imask_q == '0 && status_q == '0 && irq_n);
        end
    end

    assert_cond_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (cond_in != '0) |=> ((status_q & $past(cond_in)) == $past(cond_in)));

    assert_refresh_image_R3: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_op == 2'b00) |=>
        (image_q == (($past(host_data) & $past(status_q)) | (~$past(host_data) & $past(image_q)))));

    assert_clear_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_op == 2'b01 && cond_in == '0) |=> ((status_q & $past(host_data)) == '0));

    assert_event_beats_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_op == 2'b01) |=> ((status_q & $past(cond_in)) == $past(cond_in)));

    assert_each_pending_R7: assert property (@(posedge clk) disable iff (rst)
        ((cond_in & EACH_BITS) != '0) |=>
        ((pend_q & $past(cond_in & EACH_BITS)) == $past(cond_in & EACH_BITS)));

    assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (imask_q == '0) |-> irq_n);

    assert_noop_stable_R11: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_op == 2'b11) |=> ($stable(image_q) && $stable(imask_q)));

endmodule

bind status_latch_irq status_latch_irq_chk #(
    .W(W), .ALARM_BITS(ALARM_BITS), .ONCE_BITS(ONCE_BITS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cond_in   (cond_in),
    .host_wr   (host_wr),
    .host_op   (host_op),
    .host_data (host_data),
    .image_q   (image_out),
    .irq_n     (irq_n),
    .status_q  (status_vec),
    .pend_q    (pend_vec),
    .imask_q   (imask_vec)
);

// File: tb/sim_status_latch_irq.sv
module sim_status_latch_irq;

    typedef struct {
        string      req;
        bit         is_irq;
        logic [7:0] exp;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] cond_in;
    logic       host_wr;
    logic [1:0] host_op;
    logic [7:0] host_data;
    logic [7:0] image_out;
    logic       irq_n;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    exp_item_t sb_q[$];
    event chk_ev;

    always #5 clk = ~clk;

    status_latch_irq u0 (
        .clk       (clk),
        .rst       (rst),
        .cond_in   (cond_in),
        .host_wr   (host_wr),
        .host_op   (host_op),
        .host_data (host_data),
        .image_out (image_out),
        .irq_n     (irq_n)
    );

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                exp_item_t it;
                logic [7:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? {7'b0, irq_n} : image_out;
                n_total++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: %s actual %h expected %h", it.req,
                             it.is_irq ? "irq_n" : "image", act, it.exp);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic hw(input logic [1:0] op, input logic [7:0] d);
        host_wr   = 1'b1;
        host_op   = op;
        host_data = d;
        @(negedge clk);
        host_wr   = 1'b0;
        host_data = 8'h00;
    endtask

    task automatic exp_img(input string req, input logic [7:0] v);
        exp_item_t it;
        it.req = req; it.is_irq = 1'b0; it.exp = v;
        sb_q.push_back(it);
        ->chk_ev;
        #1;
    endtask

    task automatic exp_irq(input string req, input logic v);
        exp_item_t it;
        it.req = req; it.is_irq = 1'b1; it.exp = {7'b0, v};
        sb_q.push_back(it);
        ->chk_ev;
        #1;
    endtask

    task automatic baseline();
        cond_in = 8'h00;
        tick();
        hw(2'b01, 8'hFF);
        hw(2'b00, 8'hFF);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: requirement all, actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cond_in = 8'h00; host_wr = 1'b0; host_op = 2'b00; host_data = 8'h00;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        exp_img("R1", 8'h00);
        exp_irq("R1", 1'b1);

        hw(2'b10, 8'hFF);
        exp_irq("R10", 1'b1);

        // alarm bit 0: set, acknowledge while present, then deactivation
        cond_in = 8'h01; tick();
        exp_irq("R6", 1'b0);
        hw(2'b00, 8'hFF);
        exp_img("R2", 8'h01);
        exp_irq("R9", 1'b1);
        cond_in = 8'h00; tick();
        exp_irq("R6", 1'b0);
        hw(2'b00, 8'hFF);
        exp_irq("R9", 1'b1);

        // partial refresh and clear
        baseline();
        exp_img("R4", 8'h00);
        cond_in = 8'h02; tick(); cond_in = 8'h00; tick();
        cond_in = 8'h08; tick(); cond_in = 8'h00; tick();
        hw(2'b00, 8'h08);
        exp_img("R3", 8'h08);
        hw(2'b00, 8'h02);
        exp_img("R3", 8'h0A);
        hw(2'b01, 8'h02);
        hw(2'b00, 8'h08);
        exp_img("R3", 8'h0A);
        hw(2'b00, 8'h02);
        exp_img("R4", 8'h08);

        // clear of an alarm that is still present
        cond_in = 8'h04; tick();
        hw(2'b01, 8'h04);
        hw(2'b00, 8'h04);
        exp_img("R4", 8'h0C);
        cond_in = 8'h00; tick();
        hw(2'b01, 8'h04);
        hw(2'b00, 8'h04);
        exp_img("R4", 8'h08);

        // repeating event bit 6
        baseline();
        exp_irq("R9", 1'b1);
        cond_in = 8'h40; tick();
        exp_irq("R7", 1'b0);
        hw(2'b00, 8'h40);
        exp_irq("R7", 1'b0);
        cond_in = 8'h00; tick();
        hw(2'b00, 8'h40);
        exp_irq("R7", 1'b1);

        // single-shot event bit 4
        cond_in = 8'h10; tick();
        exp_irq("R8", 1'b0);
        hw(2'b00, 8'h10);
        exp_irq("R8", 1'b1);
        tick(); tick();
        exp_irq("R8", 1'b1);
        cond_in = 8'h00; tick();
        exp_irq("R8", 1'b1);
        cond_in = 8'h10; tick();
        exp_irq("R8", 1'b0);
        cond_in = 8'h00; tick();
        hw(2'b00, 8'hFF);

        // operation code 3 has no effect
        baseline();
        cond_in = 8'h01; tick(); cond_in = 8'h00; tick();
        exp_irq("R6", 1'b0);
        hw(2'b11, 8'h00);
        exp_irq("R11", 1'b0);
        hw(2'b11, 8'hFF);
        exp_img("R11", 8'h00);
        exp_irq("R11", 1'b0);

        // interrupt mask
        hw(2'b10, 8'h00);
        exp_irq("R10", 1'b1);
        hw(2'b10, 8'h02);
        exp_irq("R10", 1'b1);
        hw(2'b10, 8'h01);
        exp_irq("R10", 1'b0);
        hw(2'b10, 8'hFF);

        // event in the same cycle as the clear of its bit
        baseline();
        cond_in = 8'h80;
        hw(2'b01, 8'h80);
        cond_in = 8'h00;
        tick();
        hw(2'b00, 8'h80);
        exp_img("R5", 8'h80);

        #1;
        done = 1'b1;
        summary();
        $finish;
    end

endmodule